// File: doc/BRIEF.md
# Suspend Wake Event Controller

This block decides when a suspended USB-attached network bridge asks the host to wake it. A two-bit suspend depth selects which wake sources count: the shallowest depth honours GPIO edges, wake-on-LAN pattern hits and magic-packet hits; the middle depth honours GPIO edges and link status changes; the deepest depth, which is the reset default, honours GPIO edges only. In the shallowest depth the block also gates the MAC clock domain.

Each GPIO pin is synchronised and watched for an active edge, with a programmable polarity per pin. Every source has its own enable. A source that is enabled, allowed at the current depth and active while suspended sets a sticky status bit. While suspended, any set bit raises the wakeup request. Software clears status bits by writing ones. A capability input, sampled once after reset, can block the request for good.

Top module: `susp_wake_ctrl`

## Requirements
- R1: After reset the status is all zero, the wakeup request is low, the MAC clock enable is high and the suspend depth is 2.
- R2: At depth 0, wake-on-LAN (status bit 11) and magic packet (status bit 12) pulses and GPIO edges are recorded, and link change pulses are ignored.
- R3: At depth 1, link change pulses (status bit 13) and GPIO edges are recorded, and wake-on-LAN and magic packet pulses are ignored.
- R4: At depth 2 and at the spare code 3, only GPIO edges are recorded. GPIO pin k maps to status bit k.
- R5: A source whose enable bit is zero records nothing. Event enable bit 0 is wake-on-LAN, bit 1 is magic packet and bit 2 is link change.
- R6: Status bits stay set until a clear write with a one in that position. Only the bits written as one are cleared, and a set in the same cycle wins over the clear.
- R7: A GPIO active edge shows in status on the third rising clock edge after the pin changes, not earlier. A level held after clearing does not set the bit again.
- R8: With a polarity bit of 1, the pin's falling edge is the active edge and its rising edge is ignored.
- R9: The wakeup request is high exactly when the capability is latched, the block is suspended and at least one status bit is set.
- R10: The capability input is sampled on the first clock after reset release. If it was 0, the request stays low even when the input later rises.
- R11: The MAC clock enable is low exactly when the block is suspended at depth 0.
- R12: Sources active while not suspended record nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rwake_cap_i | input | 1 | Remote wakeup capability, sampled once after reset |
| suspend_i | input | 1 | Device is suspended |
| mode_we_i | input | 1 | Write strobe for the suspend depth |
| mode_wd_i | input | 2 | New suspend depth |
| cfg_we_i | input | 1 | Write strobe for enables and polarity |
| gpio_en_i | input | NUM_GPIO | Per-pin wake enable |
| gpio_pol_i | input | NUM_GPIO | Per-pin polarity, 1 selects falling edge |
| evt_en_i | input | 3 | Event enables: bit0 wake-on-LAN, bit1 magic, bit2 link |
| gpio_i | input | NUM_GPIO | Asynchronous GPIO wake pins |
| wol_i | input | 1 | Wake-on-LAN pattern hit pulse |
| magic_i | input | 1 | Magic packet hit pulse |
| link_chg_i | input | 1 | Link status change pulse |
| clr_we_i | input | 1 | Status clear strobe |
| clr_mask_i | input | NUM_GPIO+3 | Ones clear the matching status bits |
| wake_status_o | output | NUM_GPIO+3 | Sticky wake source status |
| wake_req_o | output | 1 | Remote wakeup request |
| mac_clk_en_o | output | 1 | MAC clock domain enable |

## Verification
The bench sends every event type at every depth, including the spare code 3. A wrong depth table would record an ignored source or miss an allowed one. It checks the exact cycle when a GPIO edge appears: a missing synchroniser stage shows the bit one cycle early. It also checks that a pin held high after a clear does not set the bit again, which a level detector would do. It clears one bit while another source sets it in the same cycle; a clear-first priority would lose that wake. It also resets with the capability low and raises it later, so a design that follows the live capability input would raise a request.

// File: rtl/susp_wake_pkg.sv
package susp_wake_pkg;
  typedef enum logic [1:0] {
    MODE_SHALLOW = 2'd0,
    MODE_MID     = 2'd1,
    MODE_DEEP    = 2'd2,
    MODE_SPARE   = 2'd3
  } susp_mode_e;

  localparam int EVT_WOL   = 0;
  localparam int EVT_MAGIC = 1;
  localparam int EVT_LINK  = 2;
  localparam int NUM_EVT   = 3;

  // event sources honoured at each depth; GPIO is honoured at all depths
  function automatic logic [NUM_EVT-1:0] evt_allowed(susp_mode_e m);
    logic [NUM_EVT-1:0] a;
    a = '0;
    case (m)
      MODE_SHALLOW: begin
        a[EVT_WOL]   = 1'b1;
        a[EVT_MAGIC] = 1'b1;
      end
      MODE_MID: a[EVT_LINK] = 1'b1;
      default:  a = '0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/gpio_wake_detect.sv
module gpio_wake_detect #(
  parameter int NUM_GPIO = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_GPIO-1:0] gpio_i,
  input  logic [NUM_GPIO-1:0] pol_i,
  output logic [NUM_GPIO-1:0] edge_o
);
  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
    logic sync1_q, sync2_q, prev_q, lvl;
    assign lvl = sync2_q ^ pol_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync1_q <= 1'b0;
        sync2_q <= 1'b0;
        prev_q  <= 1'b0;
      end else begin
        sync1_q <= gpio_i[g];
        sync2_q <= sync1_q;
        prev_q  <= lvl;
      end
    end
    assign edge_o[g] = lvl & ~prev_q;
  end
endmodule

// File: rtl/wake_src_gate.sv
module wake_src_gate
  import susp_wake_pkg::*;
#(
  parameter int NUM_GPIO = 11,
  localparam int STAT_W  = NUM_GPIO + NUM_EVT
) (
  input  logic                suspend_i,
  input  susp_mode_e          mode_i,
  input  logic [NUM_GPIO-1:0] gpio_edge_i,
  input  logic [NUM_GPIO-1:0] gpio_en_i,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic [NUM_EVT-1:0]  evt_en_i,
  output logic [STAT_W-1:0]   hit_o
);
  logic [NUM_EVT-1:0] allow;
  always_comb begin
    allow = evt_allowed(mode_i);
    hit_o[NUM_GPIO-1:0] = {NUM_GPIO{suspend_i}} & gpio_edge_i & gpio_en_i;
    hit_o[STAT_W-1:NUM_GPIO] = {NUM_EVT{suspend_i}} & evt_i & evt_en_i & allow;
  end
endmodule

// File: rtl/wake_status.sv
module wake_status #(
  parameter int STAT_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] stat_q, clr;
  assign clr = clr_we_i ? clr_mask_i : '0;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | set_i;  // set beats clear
  end
  assign status_o = stat_q;
endmodule

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl
  import susp_wake_pkg::*;
#(
  parameter int NUM_GPIO = 11,
  localparam int STAT_W  = NUM_GPIO + NUM_EVT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rwake_cap_i,
  input  logic                suspend_i,
  input  logic                mode_we_i,
  input  logic [1:0]          mode_wd_i,
  input  logic                cfg_we_i,
  input  logic [NUM_GPIO-1:0] gpio_en_i,
  input  logic [NUM_GPIO-1:0] gpio_pol_i,
  input  logic [NUM_EVT-1:0]  evt_en_i,
  input  logic [NUM_GPIO-1:0] gpio_i,
  input  logic                wol_i,
  input  logic                magic_i,
  input  logic                link_chg_i,
  input  logic                clr_we_i,
  input  logic [STAT_W-1:0]   clr_mask_i,
  output logic [STAT_W-1:0]   wake_status_o,
  output logic                wake_req_o,
  output logic                mac_clk_en_o
);
  susp_mode_e          mode_q;
  logic [NUM_GPIO-1:0] gpio_en_q, gpio_pol_q, gpio_edge;
  logic [NUM_EVT-1:0]  evt_en_q, evt;
  logic [STAT_W-1:0]   hit;
  logic                cap_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_DEEP;
      gpio_en_q  <= '0;
      gpio_pol_q <= '0;
      evt_en_q   <= '0;
    end else begin
      if (mode_we_i) mode_q <= susp_mode_e'(mode_wd_i);
      if (cfg_we_i) begin
        gpio_en_q  <= gpio_en_i;
        gpio_pol_q <= gpio_pol_i;
        evt_en_q   <= evt_en_i;
      end
    end
  end

  // capability captured once, on the first clock after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      cap_q   <= rwake_cap_i;
      armed_q <= 1'b1;
    end
  end

  always_comb begin
    evt            = '0;
    evt[EVT_WOL]   = wol_i;
    evt[EVT_MAGIC] = magic_i;
    evt[EVT_LINK]  = link_chg_i;
  end

  gpio_wake_detect #(.NUM_GPIO(NUM_GPIO)) i_gpio_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gpio_i (gpio_i),
    .pol_i  (gpio_pol_q),
    .edge_o (gpio_edge)
  );

  wake_src_gate #(.NUM_GPIO(NUM_GPIO)) i_gate (
    .suspend_i   (suspend_i),
    .mode_i      (mode_q),
    .gpio_edge_i (gpio_edge),
    .gpio_en_i   (gpio_en_q),
    .evt_i       (evt),
    .evt_en_i    (evt_en_q),
    .hit_o       (hit)
  );

  wake_status #(.STAT_W(STAT_W)) i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (hit),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .status_o   (wake_status_o)
  );

  assign wake_req_o   = cap_q & suspend_i & (|wake_status_o);
  assign mac_clk_en_o = ~(suspend_i & (mode_q == MODE_SHALLOW));
endmodule

// File: rtl/susp_wake_chk.sv
module susp_wake_chk #(
  parameter int STAT_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              suspend_i,
  input logic              clr_we_i,
  input logic [1:0]        mode_q,
  input logic              cap_q,
  input logic              armed_q,
  input logic [STAT_W-1:0] wake_status_o,
  input logic              wake_req_o,
  input logic              mac_clk_en_o
);
  p_req_cond_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> (suspend_i && (|wake_status_o)));

  p_no_cap_no_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_q |-> !wake_req_o);

  p_cap_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(cap_q));

  p_clk_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i && mode_q == 2'd0) |-> !mac_clk_en_o);

  p_clk_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(suspend_i && mode_q == 2'd0) |-> mac_clk_en_o);

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((wake_status_o & $past(wake_status_o)) == $past(wake_status_o)));

  p_awake_no_set_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !suspend_i |=> ((wake_status_o & ~$past(wake_status_o)) == '0));

  p_deep_gpio_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q[1] |=> ((wake_status_o[STAT_W-1 -: 3] & ~$past(wake_status_o[STAT_W-1 -: 3])) == 3'b000));
endmodule

bind susp_wake_ctrl susp_wake_chk #(.STAT_W(STAT_W)) i_susp_wake_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .suspend_i     (suspend_i),
  .clr_we_i      (clr_we_i),
  .mode_q        (mode_q),
  .cap_q         (cap_q),
  .armed_q       (armed_q),
  .wake_status_o (wake_status_o),
  .wake_req_o    (wake_req_o),
  .mac_clk_en_o  (mac_clk_en_o)
);

// File: tb/test_susp_wake_ctrl.sv
module test_susp_wake_ctrl;
  localparam int N = 11;
  localparam int W = N + 3;
  localparam logic [W-1:0] B_WOL = W'(1) << N;
  localparam logic [W-1:0] B_MAG = W'(1) << (N + 1);
  localparam logic [W-1:0] B_LNK = W'(1) << (N + 2);
  localparam logic [W-1:0] ALL   = '1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rwake_cap = 1'b1, suspend = 1'b0;
  logic mode_we = 1'b0; logic [1:0] mode_wd = '0;
  logic cfg_we = 1'b0; logic [N-1:0] gpio_en = '0, gpio_pol = '0, gpio = '0;
  logic [2:0] evt_en = '0;
  logic wol = 1'b0, magic = 1'b0, link = 1'b0;
  logic clr_we = 1'b0; logic [W-1:0] clr_mask = '0;
  logic [W-1:0] status; logic req, clk_en;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  susp_wake_ctrl #(.NUM_GPIO(N)) i_susp_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .rwake_cap_i(rwake_cap), .suspend_i(suspend),
    .mode_we_i(mode_we), .mode_wd_i(mode_wd), .cfg_we_i(cfg_we),
    .gpio_en_i(gpio_en), .gpio_pol_i(gpio_pol), .evt_en_i(evt_en),
    .gpio_i(gpio), .wol_i(wol), .magic_i(magic), .link_chg_i(link),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .wake_status_o(status), .wake_req_o(req), .mac_clk_en_o(clk_en)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic cap);
    rst_ni = 1'b0; rwake_cap = cap; suspend = 1'b0; gpio = '0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wd = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic set_cfg(input logic [N-1:0] en, input logic [N-1:0] pol, input logic [2:0] ev);
    @(negedge clk); cfg_we = 1'b1; gpio_en = en; gpio_pol = pol; evt_en = ev;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    wol = (which == 0); magic = (which == 1); link = (which == 2);
    @(negedge clk);
    wol = 1'b0; magic = 1'b0; link = 1'b0;
  endtask

  task automatic clear(input logic [W-1:0] m);
    @(negedge clk); clr_we = 1'b1; clr_mask = m;
    @(negedge clk); clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic pin(input int p, input logic v);
    @(negedge clk); gpio[p] = v;
    cyc(3);
  endtask

  task automatic t_default;
    chk("R1 status", 32'(status), 0);
    chk("R1 req", 32'(req), 0);
    chk("R1 clk_en", 32'(clk_en), 1);
    set_cfg('1, '0, 3'b111);
    @(negedge clk); suspend = 1'b1;
    #1 chk("R1 default depth not 0", 32'(clk_en), 1);
    pulse(0); pulse(1); pulse(2);
    chk("R4 depth2 events ignored", 32'(status), 0);
    pin(0, 1'b1);
    chk("R4 depth2 gpio", 32'(status), 1);
    chk("R9 req", 32'(req), 1);
    clear(ALL); pin(0, 1'b0);
  endtask

  task automatic t_mode0;
    set_mode(2'd0);
    chk("R11 gated", 32'(clk_en), 0);
    pulse(2);
    chk("R2 link ignored", 32'(status), 0);
    pulse(0);
    chk("R2 wol", 32'(status), 32'(B_WOL));
    pulse(1);
    chk("R2 magic", 32'(status), 32'(B_WOL | B_MAG));
    pin(3, 1'b1);
    chk("R2 gpio", 32'(status), 32'(B_WOL | B_MAG | W'(8)));
    clear(ALL); pin(3, 1'b0);
    @(negedge clk); suspend = 1'b0;
    #1 chk("R11 awake runs", 32'(clk_en), 1);
    @(negedge clk); suspend = 1'b1;
  endtask

  task automatic t_mode1;
    set_mode(2'd1);
    chk("R11 depth1 runs", 32'(clk_en), 1);
    pulse(0); pulse(1);
    chk("R3 wol magic ignored", 32'(status), 0);
    pulse(2);
    chk("R3 link", 32'(status), 32'(B_LNK));
    clear(ALL);
  endtask

  task automatic t_mode3;
    set_mode(2'd3);
    pulse(0); pulse(1); pulse(2);
    chk("R4 spare code events ignored", 32'(status), 0);
    pin(10, 1'b1);
    chk("R4 spare code gpio", 32'(status), 32'(W'(1) << 10));
    clear(ALL); pin(10, 1'b0);
  endtask

  task automatic t_enable;
    set_mode(2'd0);
    set_cfg(~(N'(1) << 5), '0, 3'b101);
    pin(5, 1'b1);
    pulse(1);
    chk("R5 disabled sources", 32'(status), 0);
    pulse(0);
    chk("R5 enabled wol", 32'(status), 32'(B_WOL));
    clear(ALL); pin(5, 1'b0);
    set_cfg('1, '0, 3'b111);
  endtask

  task automatic t_w1c;
    pulse(0); pulse(1); pin(1, 1'b1);
    chk("R6 set", 32'(status), 32'(B_WOL | B_MAG | W'(2)));
    clear(B_MAG);
    chk("R6 partial clear", 32'(status), 32'(B_WOL | W'(2)));
    cyc(4);
    chk("R6 sticky", 32'(status), 32'(B_WOL | W'(2)));
    @(negedge clk); wol = 1'b1; clr_we = 1'b1; clr_mask = B_WOL | W'(2);
    @(negedge clk); wol = 1'b0; clr_we = 1'b0; clr_mask = '0;
    chk("R6 set beats clear", 32'(status), 32'(B_WOL));
    clear(ALL); pin(1, 1'b0);
  endtask

  task automatic t_gpio_timing;
    @(negedge clk); gpio[4] = 1'b1;
    cyc(2);
    chk("R7 not before third edge", 32'(status), 0);
    cyc(1);
    chk("R7 third edge", 32'(status), 32'h10);
    clear(ALL);
    cyc(4);
    chk("R7 held level no retrigger", 32'(status), 0);
    pin(4, 1'b0);
    chk("R7 fall ignored", 32'(status), 0);
  endtask

  task automatic t_pol;
    @(negedge clk); suspend = 1'b0;
    set_cfg('1, N'(4), 3'b111);
    cyc(4);
    @(negedge clk); suspend = 1'b1;
    pin(2, 1'b1);
    chk("R8 rise ignored", 32'(status), 0);
    pin(2, 1'b0);
    chk("R8 fall detected", 32'(status), 32'h4);
    clear(ALL);
    @(negedge clk); suspend = 1'b0;
    set_cfg('1, '0, 3'b111);
    cyc(4);
    @(negedge clk); suspend = 1'b1;
  endtask

  task automatic t_awake;
    @(negedge clk); suspend = 1'b0;
    pulse(0); pin(6, 1'b1);
    chk("R12 awake ignored", 32'(status), 0);
    chk("R9 awake no req", 32'(req), 0);
    pin(6, 1'b0);
    @(negedge clk); suspend = 1'b1;
    pulse(0);
    chk("R9 req on wol", 32'(req), 1);
    @(negedge clk); suspend = 1'b0;
    #1;
    chk("R9 req drops when awake", 32'(req), 0);
    chk("R6 status kept when awake", 32'(status), 32'(B_WOL));
    clear(ALL);
  endtask

  task automatic t_cap;
    do_reset(1'b0);
    cyc(1); rwake_cap = 1'b1;
    set_cfg('1, '0, 3'b111);
    @(negedge clk); suspend = 1'b1;
    pin(0, 1'b1);
    chk("R10 status still recorded", 32'(status), 1);
    chk("R10 no req without capability", 32'(req), 0);
    pin(0, 1'b0);
  endtask

  initial begin
    do_reset(1'b1);
    t_default;
    t_mode0;
    t_mode1;
    t_mode3;
    t_enable;
    t_w1c;
    t_gpio_timing;
    t_pol;
    t_awake;
    t_cap;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule